// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block lets software talk to external Ethernet PHYs over the two-wire management bus. Software places a complete, preformatted 32-bit management frame in the data register. The engine then sends a preamble of 32 ones, followed by that word, most significant bit first, on the management data line. It generates the management clock from the system clock through a programmable divider.

When the word encodes a read, the engine lets go of the data line for the turnaround and data phases. It shifts in the 16 bits the PHY returns and writes them into the low half of the data register. Every completed frame raises a sticky completion event. Software clears the event by writing a one to it, and the event reaches the interrupt output only when its mask bit is set.

Software uses the block by polling or by interrupt: program the speed, write a frame word, wait for the event, read the result back from the data register, and clear the event. The frame word layout is fixed by the bus protocol:
- start = 01 in bits 31:30
- opcode in bits 29:28: 10 for read, 01 for write
- PHY address in bits 27:23
- register number in bits 22:18
- turnaround = 10 in bits 17:16
- data in bits 15:0

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset all four registers read as zero, the management clock is low, the data line is not driven, and the interrupt is low.
- R2: The register at address 1 holds a 6-bit divisor in bits 6:1 and reads back only those bits. While a frame runs, each management clock period is 2 × divisor system clock cycles.
- R3: Writing the data register (address 0) starts a frame of 64 management clock periods. The first 32 periods carry a driven 1. The next 32 carry the written word, bit 31 first. A write frame drives the line in all 64 periods.
- R4: A read frame is one whose bits 29:28 are 10. For such a frame the line is released for the last 18 periods. The 16 bits sampled in the last 16 periods, first sample as bit 15, replace bits 15:0 of the data register, and bits 31:16 keep the written value.
- R5: If no PHY drives the line during a read, the returned data is 0xFFFF, because the released line is pulled high.
- R6: At the end of every frame, bit 23 of the event register (address 2) becomes 1. Writing 1 to bit 23 clears it. Writing 0 to bit 23 leaves it unchanged.
- R7: The mask register (address 3) holds bit 23 and resets to zero. The interrupt output is the event bit ANDed with the mask bit, delayed by one register stage.
- R8: A write to the data register while a frame is in progress is ignored. The running frame and the data register are not affected, and no second frame follows.
- R9: While the divisor is zero the management clock stays low, and a write to the data register is ignored: no frame starts and the data register keeps its value.
- R10: The engine changes the data line value and its drive enable only on the system clock edge where the management clock falls. It samples the line on the edge where the management clock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 data, 1 speed, 2 event, 3 mask |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the register selected in the previous cycle |
| irq | output | 1 | Masked completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line input, pulled high when nobody drives it |

## Verification
A wrong slot counter or divider state shows up within one frame at the pins: the preamble would have the wrong number of ones, the frame bits would be shifted, the release window would not cover exactly 18 slots, or the measured clock period would differ from 2 × divisor.

A wrong capture or start-gating state shows up as soon as the data register is read back after completion. It would hold a wrong returned value, hold a word that should have been ignored, or reveal that a second frame ran.

Event and mask errors reach the interrupt pin within two cycles of the register write that should change them.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic [1:0] {
    RA_DATA  = 2'd0,
    RA_SPEED = 2'd1,
    RA_EVENT = 2'd2,
    RA_MASK  = 2'd3
  } reg_addr_e;

  localparam int          EVT_BIT = 23;
  localparam logic [1:0]  OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             run;
  logic             wrap;

  assign run  = en && (div != '0);
  assign wrap = run && (cnt == div - 1'b1);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_HALTED: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !mdc); // R9

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(mdc)) |-> ($past(cnt) == $past(div) - 1'b1)); // R2
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] word_in,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic               is_rd,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  cap
);
  localparam int SLOTS = PRE_LEN + FRAME_W;
  localparam int CW    = $clog2(SLOTS);
  localparam int FW_W  = $clog2(FRAME_W);
  localparam logic [CW-1:0]   PRE_C   = CW'(PRE_LEN);
  localparam logic [CW-1:0]   LAST_C  = CW'(SLOTS - 1);
  localparam logic [CW-1:0]   TA_C    = CW'(SLOTS - DATA_W - 2);
  localparam logic [CW-1:0]   DAT_C   = CW'(SLOTS - DATA_W);
  localparam logic [FW_W-1:0] TOP_IDX = FW_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] word;
  logic [CW-1:0]      cnt;

  function automatic logic slot_bit(input logic [CW-1:0] k, input logic [FRAME_W-1:0] w);
    logic [FW_W-1:0] j;
    j = FW_W'(k - PRE_C);
    if (k < PRE_C) return 1'b1;
    return w[TOP_IDX - j];
  endfunction

  function automatic logic slot_oe(input logic [CW-1:0] k, input logic rd);
    return !(rd && (k >= TA_C));
  endfunction

  assign done = busy && fall && (cnt == LAST_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      word    <= '0;
      is_rd   <= 1'b0;
      cnt     <= '0;
      cap     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      word    <= word_in;
      is_rd   <= (word_in[FRAME_W-3 -: 2] == OP_READ);
      cnt     <= '0;
      cap     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise && is_rd && (cnt >= DAT_C))
        cap <= {cap[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (cnt == LAST_C) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          cnt     <= cnt + 1'b1;
          mdio_o  <= slot_bit(cnt + 1'b1, word);
          mdio_oe <= slot_oe(cnt + 1'b1, is_rd);
        end
      end
    end
  end

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && (!$stable(mdio_o) || !$stable(mdio_oe))) |-> $past(fall)); // R10

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && rise && is_rd && (cnt >= DAT_C)) |-> !mdio_oe); // R4

  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_rd) |-> mdio_oe); // R3
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;

  logic [FRAME_W-1:0] data_q;
  logic [DIV_W-1:0]   div_q;
  logic               ev_q;
  logic               mask_q;
  logic               wr_data;
  logic               start;
  logic               busy;
  logic               done;
  logic               is_rd;
  logic               rise;
  logic               fall;
  logic [DATA_W-1:0]  cap;

  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign start   = wr_data && !busy && (div_q != '0);

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (busy),
    .div  (div_q),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio_frame_eng #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .word_in (reg_wdata),
    .rise    (rise),
    .fall    (fall),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .done    (done),
    .is_rd   (is_rd),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .cap     (cap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      div_q  <= '0;
      ev_q   <= 1'b0;
      mask_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (start)
        data_q <= reg_wdata;
      else if (done && is_rd)
        data_q[DATA_W-1:0] <= cap;

      if (reg_wr && (reg_addr == RA_SPEED))
        div_q <= reg_wdata[DIV_W:1];

      if (done)
        ev_q <= 1'b1;
      else if (reg_wr && (reg_addr == RA_EVENT) && reg_wdata[EVT_BIT])
        ev_q <= 1'b0;

      if (reg_wr && (reg_addr == RA_MASK))
        mask_q <= reg_wdata[EVT_BIT];

      irq <= ev_q && mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_DATA:  reg_rdata <= data_q;
        RA_SPEED: reg_rdata <= {{(31-DIV_W){1'b0}}, div_q, 1'b0};
        RA_EVENT: reg_rdata <= 32'(ev_q) << EVT_BIT;
        default:  reg_rdata <= 32'(mask_q) << EVT_BIT;
      endcase
    end
  end

  AST_EVENT_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_q) |-> $past(done)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mask_q)); // R7

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_data && busy && !done) |=> $stable(data_q)); // R8

  AST_ZERO_SPEED_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((div_q == '0) && !busy) |=> !busy); // R9
endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, mdc, mdio_o, mdio_oe, mdio_i;

  localparam logic [4:0] PHY_ADR = 5'd6;
  localparam logic [31:0] EVT = 32'h0080_0000;

  int checks = 0;
  int errors = 0;

  // PHY responder state
  int          rise_n = 0;
  int          pre_ones = 0;
  int          rel_cnt = 0;
  logic [31:0] cap_word = 32'd0;
  logic        phy_drv = 1'b0;
  logic        phy_bit = 1'b0;
  logic        rsp_active = 1'b0;
  logic [15:0] resp = 16'd0;
  longint      last_t = 0;
  int          per_min = 1000000;
  int          per_max = 0;

  always #5 clk = ~clk;

  mdio_mgmt_ctrl u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  function automatic logic [15:0] phy_val(input logic [4:0] a, input logic [4:0] r);
    return {a, r, a ^ r, 1'b1};
  endfunction

  function automatic logic [31:0] mk_rd(input logic [4:0] a, input logic [4:0] r);
    return 32'h6002_0000 | (32'(a) << 23) | (32'(r) << 18);
  endfunction

  function automatic logic [31:0] mk_wr(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
    return 32'h5002_0000 | (32'(a) << 23) | (32'(r) << 18) | 32'(d);
  endfunction

  always @(posedge mdc) begin
    if (rise_n > 0) begin
      int per;
      per = int'(($time - last_t) / 10);
      if (per < per_min) per_min = per;
      if (per > per_max) per_max = per;
    end
    last_t = $time;
    if (rise_n < 32) begin
      if (mdio_oe && mdio_o) pre_ones++;
    end else if (rise_n < 64) begin
      if (mdio_oe) cap_word[63-rise_n] = mdio_o;
      else rel_cnt++;
    end
    rise_n++;
  end

  always @(negedge mdc) begin
    if (rise_n == 46) begin
      rsp_active = (cap_word[29:28] == 2'b10) && (cap_word[27:23] == PHY_ADR);
      resp = phy_val(cap_word[27:23], cap_word[22:18]);
      phy_drv = 1'b0;
    end else if (rise_n == 47) begin
      phy_drv = rsp_active;
      phy_bit = 1'b0;
    end else if (rise_n >= 48 && rise_n <= 63) begin
      phy_drv = rsp_active;
      phy_bit = resp[63-rise_n];
    end else begin
      phy_drv = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic phy_clear();
    rise_n = 0; pre_ones = 0; rel_cnt = 0; cap_word = 32'd0;
    phy_drv = 1'b0; rsp_active = 1'b0; per_min = 1000000; per_max = 0;
  endtask

  task automatic wait_evt(input int div, output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int i = 0; i < 140*div + 40; i++) begin
      rd(2'd2, v);
      if (v[23]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_frame(input logic [31:0] w, input int div);
    bit ok;
    bit rdf;
    logic [31:0] v, exp;
    rdf = (w[29:28] == 2'b10);
    wr(2'd1, 32'(div) << 1);
    phy_clear();
    wr(2'd0, w);
    wait_evt(div, ok);
    check(ok, "R6 event after frame", 32'(ok), 32'd1);
    check(rise_n == 64, "R3 clock periods", 32'(rise_n), 32'd64);
    check(pre_ones == 32, "R3 preamble ones", 32'(pre_ones), 32'd32);
    check(per_min == 2*div && per_max == 2*div, "R2 mdc period",
          32'(per_max), 32'(2*div));
    if (rdf) begin
      check(cap_word[31:18] == w[31:18], "R4 read header bits", cap_word, w);
      check(rel_cnt == 18, "R4 released slots", 32'(rel_cnt), 32'd18);
      exp = {w[31:16], (w[27:23] == PHY_ADR) ? phy_val(w[27:23], w[22:18]) : 16'hFFFF};
      rd(2'd0, v);
      check(v == exp, (w[27:23] == PHY_ADR) ? "R4 read result" : "R5 absent phy",
            v, exp);
    end else begin
      check(cap_word == w, "R3 write frame bits", cap_word, w);
      check(rel_cnt == 0, "R3 write driven", 32'(rel_cnt), 32'd0);
      rd(2'd0, v);
      check(v == w, "R3 data register", v, w);
    end
    wr(2'd2, EVT);
    rd(2'd2, v);
    check(v == 32'd0, "R6 event cleared", v, 32'd0);
  endtask

  initial begin
    int limit;
    limit = 190000;
    repeat (limit) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", limit);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, keep;
    int seed_dummy;
    bit ok;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check(mdc == 1'b0 && mdio_oe == 1'b0 && irq == 1'b0, "R1 pins at reset",
          {29'd0, mdc, mdio_oe, irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 32'd0, "R1 register reset", v, 32'd0);
    end

    // R2 speed readback keeps only bits 6:1
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v);
    check(v == 32'h0000_007E, "R2 speed readback", v, 32'h7E);

    // directed frames
    run_frame(mk_rd(PHY_ADR, 5'd2), 1);
    run_frame(mk_rd(5'd9, 5'd3), 2);
    run_frame(mk_wr(PHY_ADR, 5'd0, 16'hA5C3), 3);

    // R6 writing zero does not clear, R7 masking
    wr(2'd1, 32'd2);
    phy_clear();
    wr(2'd0, mk_wr(5'd1, 5'd4, 16'h1234));
    wait_evt(1, ok);
    check(ok, "R6 event set", 32'(ok), 32'd1);
    wr(2'd2, 32'h0000_0000);
    rd(2'd2, v);
    check(v == EVT, "R6 zero write keeps event", v, EVT);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R7 irq masked", 32'(irq), 32'd0);
    wr(2'd3, EVT);
    rd(2'd3, v);
    check(v == EVT, "R7 mask readback", v, EVT);
    check(irq == 1'b1, "R7 irq asserted", 32'(irq), 32'd1);
    wr(2'd2, EVT);
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R7 irq after clear", 32'(irq), 32'd0);
    wr(2'd3, 32'd0);

    // R8 write while busy ignored
    wr(2'd1, 32'd4);
    phy_clear();
    wr(2'd0, mk_wr(5'd3, 5'd7, 16'hBEEF));
    repeat (40) @(negedge clk);
    wr(2'd0, mk_rd(PHY_ADR, 5'd1));
    wait_evt(2, ok);
    check(cap_word == mk_wr(5'd3, 5'd7, 16'hBEEF), "R8 frame unchanged",
          cap_word, mk_wr(5'd3, 5'd7, 16'hBEEF));
    rd(2'd0, v);
    check(v == mk_wr(5'd3, 5'd7, 16'hBEEF), "R8 data unchanged", v, mk_wr(5'd3, 5'd7, 16'hBEEF));
    repeat (60) @(negedge clk);
    check(rise_n == 64 && mdc == 1'b0, "R8 no second frame", 32'(rise_n), 32'd64);
    wr(2'd2, EVT);

    // R9 zero divisor: clock halted, write ignored
    rd(2'd0, keep);
    wr(2'd1, 32'd0);
    phy_clear();
    wr(2'd0, mk_rd(PHY_ADR, 5'd5));
    repeat (60) @(negedge clk);
    check(rise_n == 0 && mdc == 1'b0, "R9 mdc halted", 32'(rise_n), 32'd0);
    rd(2'd0, v);
    check(v == keep, "R9 data kept", v, keep);
    rd(2'd2, v);
    check(v == 32'd0, "R9 no event", v, 32'd0);

    // random frames (R3 R4 R5 R2 R10 via pin capture)
    for (int n = 0; n < 24; n++) begin
      logic [4:0] a, r;
      logic [15:0] d;
      int div;
      case ($urandom % 5)
        0: div = 1;
        1: div = 2;
        2: div = 3;
        3: div = 4;
        default: div = 7;
      endcase
      a = ($urandom % 2 == 0) ? PHY_ADR : 5'($urandom);
      r = 5'($urandom);
      d = 16'($urandom);
      if ($urandom % 2 == 0) run_frame(mk_rd(a, r), div);
      else run_frame(mk_wr(a, r, d), div);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule